// File: doc/BRIEF.md
# Clock Second-Chance Victim Selector

This block picks which physical frame to reclaim when a new page has to be brought in. It holds one reference bit and one modify bit for each of `NFRAMES` frames, plus a hand that points at one frame of a circular list. Accesses from the translation path mark a frame as referenced, and write accesses also mark it as modified. Loading a fresh page into a frame marks it referenced and clean.

When the caller raises a victim request, the block walks the circle from the hand, one frame per clock. A frame that was referenced loses its mark and is passed over. The first frame found unmarked is the victim. Its index and its modify bit come back on a valid/ready response, so the caller knows whether the old contents need writing back first. The hand then rests just past the victim, ready for the next request.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` is 0, all reference and modify bits are 0, and the hand is on frame 0. The first victim is therefore frame 0, clean, and it is reported after one sweep step.
- R2: The sweep looks at exactly one frame per clock cycle, going up in index order and wrapping from `NFRAMES-1` to 0.
- R3: The victim is the first frame the sweep finds with its stored reference bit at 0. `rsp_frame` carries that frame's index.
- R4: A frame that the sweep finds with its reference bit at 1 has that bit cleared and is skipped. If nothing sets the bit again, the next pass of the hand picks that frame.
- R5: Once a victim is chosen, the hand sits one position past it, wrapping at `NFRAMES`. The next request starts its sweep there.
- R6: An access (`ref_valid`) to frame f sets the reference bit of f to 1.
- R7: If an access to a frame arrives in the same cycle that the sweep clears that frame's reference bit, the bit ends up at 1.
- R8: If every reference bit is 1 when a request is accepted, the sweep runs for `NFRAMES+1` steps and picks the frame it started on. `rsp_valid` rises `NFRAMES+1` cycles after the accepting edge.
- R9: A load (`fill_valid`) into frame f sets its reference bit to 1 and its modify bit to 0.
- R10: An access with `ref_write` at 1 sets the frame's modify bit. `rsp_dirty` reports the victim's modify bit as it stood when the victim was chosen.
- R11: A request is accepted only when `req_ready` is 1, which is only while no sweep or response is pending. `rsp_valid`, `rsp_frame` and `rsp_dirty` hold steady until the cycle where `rsp_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | An access to frame `ref_frame` occurred |
| ref_frame | input | IW | Frame touched by the access |
| ref_write | input | 1 | The access was a write (marks the frame modified) |
| fill_valid | input | 1 | A new page was loaded into `fill_frame` |
| fill_frame | input | IW | Frame that received the new page |
| req_valid | input | 1 | Request for a victim frame |
| req_ready | output | 1 | Selector is idle and can accept a request |
| rsp_valid | output | 1 | Victim result is available |
| rsp_ready | input | 1 | Caller takes the result |
| rsp_frame | output | IW | Index of the chosen victim |
| rsp_dirty | output | 1 | Victim's modify bit: write-back is needed |

## Verification
The bench instantiates the selector with `NFRAMES` set to 6. Because 6 is not a power of two, the hand has to wrap from frame 5 back to 0 without ever reaching the index values 6 and 7 that the 3-bit hand could hold. The value is also small enough that a full pass where every bit is set, which takes seven steps, is short to set up. One access is timed to land in the exact cycle the hand clears that frame, to test the set-wins rule. A frame that was written and then refilled is later evicted, to confirm that its modify bit reads clean.

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NFRAMES = 8,
  localparam int IW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_valid,
  input  logic [IW-1:0] ref_frame,
  input  logic          ref_write,
  input  logic          fill_valid,
  input  logic [IW-1:0] fill_frame,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [IW-1:0] rsp_frame,
  output logic          rsp_dirty
);
  typedef enum logic [1:0] {ST_IDLE, ST_SWEEP, ST_RESP} st_t;

  st_t st;
  logic [NFRAMES-1:0] ref_bits, mod_bits, ref_nxt, mod_nxt;
  logic [IW-1:0] hand, hand_inc, victim;
  logic victim_dirty;
  logic sweeping, cur_ref;

  assign sweeping  = (st == ST_SWEEP);
  assign cur_ref   = ref_bits[hand];
  assign hand_inc  = (hand == IW'(NFRAMES - 1)) ? '0 : hand + 1'b1;
  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_frame = victim;
  assign rsp_dirty = victim_dirty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      hand         <= '0;
      victim       <= '0;
      victim_dirty <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) st <= ST_SWEEP;
        ST_SWEEP: begin
          hand <= hand_inc;
          if (!cur_ref) begin
            victim       <= hand;
            victim_dirty <= mod_bits[hand];
            st           <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NFRAMES; i++) begin : frame_g
    logic hit_ref, hit_fill, wipe;
    assign hit_ref  = ref_valid && (ref_frame == IW'(i));
    assign hit_fill = fill_valid && (fill_frame == IW'(i));
    assign wipe     = sweeping && cur_ref && (hand == IW'(i));
    assign ref_nxt[i] = (ref_bits[i] & ~wipe) | hit_ref | hit_fill;
    assign mod_nxt[i] = (mod_bits[i] & ~hit_fill) | (hit_ref & ref_write);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_bits <= '0;
      mod_bits <= '0;
    end else begin
      ref_bits <= ref_nxt;
      mod_bits <= mod_nxt;
    end
  end
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int NFRAMES = 8,
  localparam int IW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ref_valid,
  input logic [IW-1:0]      ref_frame,
  input logic               ref_write,
  input logic               fill_valid,
  input logic [IW-1:0]      fill_frame,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [IW-1:0]      rsp_frame,
  input logic               rsp_dirty,
  input logic [NFRAMES-1:0] ref_bits,
  input logic [NFRAMES-1:0] mod_bits,
  input logic [IW-1:0]      hand,
  input logic               sweeping
);
  // R11
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_frame) && $stable(rsp_dirty));

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R5
  hand_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> hand == ((rsp_frame == IW'(NFRAMES - 1)) ? '0 : rsp_frame + 1'b1));

  // R2
  hand_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweeping |=> hand == (($past(hand) == IW'(NFRAMES - 1)) ? '0 : $past(hand) + 1'b1));

  // R3
  victim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> ((($past(ref_bits) >> rsp_frame) & NFRAMES'(1)) == '0));

  // R6
  ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_valid && (int'(ref_frame) < NFRAMES) |=> ref_bits[$past(ref_frame)]);

  // R9
  fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid && (int'(fill_frame) < NFRAMES) && !(ref_valid && ref_write && ref_frame == fill_frame)
    |=> ref_bits[$past(fill_frame)] && !mod_bits[$past(fill_frame)]);
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NFRAMES(NFRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
  .ref_write(ref_write), .fill_valid(fill_valid), .fill_frame(fill_frame),
  .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_frame(rsp_frame), .rsp_dirty(rsp_dirty),
  .ref_bits(ref_bits), .mod_bits(mod_bits), .hand(hand), .sweeping(sweeping)
);

// File: tb/tb_clock_victim_sel.sv
`timescale 1ns/1ps
module tb_clock_victim_sel;
  localparam int N  = 6;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic ref_valid = 0, ref_write = 0, fill_valid = 0, req_valid = 0, rsp_ready = 0;
  logic [IW-1:0] ref_frame = '0, fill_frame = '0;
  logic req_ready, rsp_valid, rsp_dirty;
  logic [IW-1:0] rsp_frame;

  always #2.5 clk = ~clk;

  clock_victim_sel #(.NFRAMES(N)) dut (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_frame(ref_frame),
    .ref_write(ref_write), .fill_valid(fill_valid), .fill_frame(fill_frame),
    .req_valid(req_valid), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_frame(rsp_frame), .rsp_dirty(rsp_dirty)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int m_ref[N], m_mod[N];
  int m_hand = 0, m_st = 0, m_vic = 0, m_dirty = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int o_ref[N];
    int o_mod[N];
    if (!rst_n) begin
      foreach (m_ref[k]) begin m_ref[k] = 0; m_mod[k] = 0; end
      m_hand = 0; m_st = 0; m_vic = 0; m_dirty = 0;
      return;
    end
    o_ref = m_ref; o_mod = m_mod;
    case (m_st)
      0: if (req_valid) m_st = 1;
      1: begin
        if (o_ref[m_hand] == 1) m_ref[m_hand] = 0;
        else begin m_vic = m_hand; m_dirty = o_mod[m_hand]; m_st = 2; end
        m_hand = (m_hand + 1) % N;
      end
      default: if (rsp_ready) m_st = 0;
    endcase
    if (fill_valid && fill_frame < N) begin m_ref[fill_frame] = 1; m_mod[fill_frame] = 0; end
    if (ref_valid && ref_frame < N) begin
      m_ref[ref_frame] = 1;
      if (ref_write) m_mod[ref_frame] = 1;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    model_step();
    check("R11 req_ready", int'(req_ready), int'(m_st == 0));
    check("R11 rsp_valid", int'(rsp_valid), int'(m_st == 2));
    if (m_st == 2) begin
      check("R3 rsp_frame", int'(rsp_frame), m_vic);
      check("R10 rsp_dirty", int'(rsp_dirty), m_dirty);
    end
  endtask

  task automatic do_ref(int f, bit w);
    ref_valid = 1; ref_frame = IW'(f); ref_write = w;
    tick();
    ref_valid = 0; ref_write = 0;
  endtask

  task automatic do_fill(int f);
    fill_valid = 1; fill_frame = IW'(f);
    tick();
    fill_valid = 0;
  endtask

  task automatic run_victim(output int f, output int d, output int lat, input int poke_at, input int poke_frame);
    req_valid = 1;
    tick();
    req_valid = 0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      if (lat == poke_at) begin ref_valid = 1; ref_frame = IW'(poke_frame); end
      tick();
      ref_valid = 0;
      lat++;
    end
    f = int'(rsp_frame); d = int'(rsp_dirty);
    repeat (2) tick();
    check("R11 frame held", int'(rsp_frame), f);
    rsp_ready = 1;
    tick();
    rsp_ready = 0;
  endtask

  initial begin
    int f, d, lat;
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    check("R1 idle ready", int'(req_ready), 1);
    check("R1 no response", int'(rsp_valid), 0);

    run_victim(f, d, lat, -1, 0);
    check("R1 first victim", f, 0);
    check("R1 first dirty", d, 0);
    check("R1 first latency", lat, 1);

    do_ref(1, 0);
    do_ref(2, 1);
    run_victim(f, d, lat, -1, 0);
    check("R6 referenced frames skipped", f, 3);
    check("R2 one frame per cycle", lat, 3);

    run_victim(f, d, lat, -1, 0);
    check("R5 hand past victim", f, 4);
    check("R5 latency", lat, 1);
    run_victim(f, d, lat, -1, 0);
    check("R2 frame 5", f, 5);
    run_victim(f, d, lat, -1, 0);
    check("R2 wrap to 0", f, 0);
    run_victim(f, d, lat, -1, 0);
    check("R4 cleared bit evicts", f, 1);
    run_victim(f, d, lat, -1, 0);
    check("R4 cleared frame 2", f, 2);
    check("R10 written victim dirty", d, 1);

    do_fill(2);
    for (int k = 0; k < N; k++) if (k != 2) do_ref(k, 0);
    run_victim(f, d, lat, -1, 0);
    check("R8 all set returns start", f, 3);
    check("R8 full sweep latency", lat, N + 1);
    for (int k = 0; k < 4; k++) run_victim(f, d, lat, -1, 0);
    check("R2 after full sweep", f, 1);
    run_victim(f, d, lat, -1, 0);
    check("R9 filled frame", f, 2);
    check("R9 fill clears modify", d, 0);

    for (int k = 0; k < N; k++) do_ref(k, 0);
    run_victim(f, d, lat, 1, 4);
    check("R8 second full sweep", f, 3);
    check("R8 second latency", lat, N + 1);
    run_victim(f, d, lat, -1, 0);
    check("R7 set beats clear", f, 5);
    check("R7 latency", lat, 2);

    repeat (3) tick();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule